// File: doc/BRIEF.md
# Reloading 24-Bit Tick Timer

This block is a periodic tick source for a processor subsystem. A 24-bit counter counts down by one on each count cycle and, once it has reached zero, takes the programmed reload value on the next count cycle. Software programs a period of P count cycles by writing P-1 into the reload register. A sticky wrap flag records each one-to-zero step and is cleared when software reads the control register. An optional one-cycle interrupt pulse marks each wrap.

Three word registers sit on a simple synchronous bus with an address, a write strobe, a read strobe and 32-bit data in each direction. The control register selects whether counting runs on every core clock or only on cycles where a reference tick input is high. A write of any value to the current-value register restarts the count from zero, so the next count cycle takes the reload value.

Top module: `tick_timer`

## Requirements
- R1: The counter and the reload register are 24 bits wide (largest value 0x00FFFFFF); bits 31:24 written to the reload or current-value register are ignored and read back as zero.
- R2: On each count cycle a non-zero counter decreases by one, and a counter at zero takes the reload value instead.
- R3: With reload value N greater than zero and counting on every clock, wraps recur every N+1 count cycles.
- R4: Bit 16 of the control register (wrap flag) is set by the count cycle in which the counter steps from 1 to 0.
- R5: A control register read returns the flag as it stood before the read and then clears it, except when a new 1-to-0 step happens in that same cycle, in which case the flag remains set.
- R6: A write of any value to the current-value register sets the counter to zero and clears the wrap flag; it takes precedence over any count step in the same cycle, which then raises no wrap.
- R7: Control bit 0 enables counting, bit 1 enables the interrupt, bit 2 selects the count source; other control bits read as zero. With bit 0 clear the counter holds its value.
- R8: When bit 1 is set, the irq output is high for exactly the one cycle after each 1-to-0 step; it stays low when bit 1 is clear.
- R9: With bit 2 set every clock cycle is a count cycle; with bit 2 clear only cycles where ref_tick is high are count cycles.
- R10: The control, reload and current-value registers sit at byte offsets 0x0, 0x4 and 0x8; any other offset reads as zero and writes to it have no effect.
- R11: Read data for a read strobe appears on bus_rdata in the cycle after the strobe and holds until the next read.
- R12: After reset all control bits, the flag, the reload value, the counter and irq are zero.
- R13: A counter at zero when counting is enabled takes the reload value on the first count cycle, so with reload N the first wrap comes N+1 count cycles after enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick, a count enable when the core-clock source is not selected |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq | output | 1 | One-cycle interrupt pulse on each wrap |

## Verification
Every result of this block lands one clock edge after its cause: the counter and flag change at the edge that samples a count cycle or a write, irq rises at the edge on which the counter reaches zero, and read data is registered at the edge that samples the read strobe. The bench keeps a behavioural model that applies the same stimulus at each rising edge, and compares irq after every edge and bus_rdata after every edge that took a read, sampling on the falling edge. Directed checks count falling edges from an enabling write to the first irq pulse and between pulses to confirm the N+1 period and the start-from-zero delay.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int CNT_W    = 24;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;

    localparam int RUN_BIT  = 0;
    localparam int IE_BIT   = 1;
    localparam int SRC_BIT  = 2;
    localparam int FLAG_BIT = 16;

    localparam logic [7:0] OFS_CTRL    = 8'h00;
    localparam logic [7:0] OFS_RELOAD  = 8'h04;
    localparam logic [7:0] OFS_CURRENT = 8'h08;

    typedef enum logic [1:0] {
        SEL_CTRL,
        SEL_RELOAD,
        SEL_CURRENT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic core_src;
        logic irq_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_reload;
        logic wr_current;
        logic rd_ctrl;
    } bus_ops_t;

    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            OFS_CTRL:    return SEL_CTRL;
            OFS_RELOAD:  return SEL_RELOAD;
            OFS_CURRENT: return SEL_CURRENT;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run      = w[RUN_BIT];
        c.irq_en   = w[IE_BIT];
        c.core_src = w[SRC_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c, input logic flag);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[RUN_BIT]  = c.run;
        w[IE_BIT]   = c.irq_en;
        w[SRC_BIT]  = c.core_src;
        w[FLAG_BIT] = flag;
        return w;
    endfunction

endpackage

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    input  logic          flag,
    input  logic [CW-1:0] cnt,
    output ctrl_t         ctrl,
    output logic [CW-1:0] reload,
    output bus_ops_t      ops,
    output logic [DW-1:0] bus_rdata
);

    reg_sel_e sel;
    logic [DW-1:0] rd_word;

    always_comb begin
        sel            = decode_ofs(8'(bus_addr));
        ops.wr_ctrl    = bus_wr && (sel == SEL_CTRL);
        ops.wr_reload  = bus_wr && (sel == SEL_RELOAD);
        ops.wr_current = bus_wr && (sel == SEL_CURRENT);
        ops.rd_ctrl    = bus_rd && (sel == SEL_CTRL);
    end

    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_CTRL:    rd_word = ctrl_to_word(ctrl, flag);
            SEL_RELOAD:  rd_word[CW-1:0] = reload;
            SEL_CURRENT: rd_word[CW-1:0] = cnt;
            default:     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            reload    <= '0;
            bus_rdata <= '0;
        end else begin
            if (ops.wr_ctrl)   ctrl   <= ctrl_from_word(bus_wdata);
            if (ops.wr_reload) reload <= bus_wdata[CW-1:0];
            if (bus_rd)        bus_rdata <= rd_word;
        end
    end

    // R1: the upper byte never appears on reload or current readback
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rd && (sel != SEL_CTRL) |=> bus_rdata[DW-1:CW] == '0);

    // R10: an unmapped offset reads zero
    a_r10_unmapped: assert property (@(posedge clk) disable iff (rst)
        bus_rd && (sel == SEL_NONE) |=> bus_rdata == '0);

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CW = tick_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    input  logic          clr,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic at_zero;

    assign at_zero = (cnt == '0);
    assign wrap    = cnt_en && !clr && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt_en) begin
            if (at_zero) cnt <= reload;
            else         cnt <= cnt - ONE;
        end
    end

    // R2: zero takes the reload value on a count cycle
    a_r2_reload: assert property (@(posedge clk) disable iff (rst)
        cnt_en && !clr && (cnt == '0) |=> cnt == $past(reload));

    // R2: non-zero decreases by one on a count cycle
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        cnt_en && !clr && (cnt != '0) |=> cnt == $past(cnt) - ONE);

    // R7: no count cycle and no clear leaves the counter unchanged
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en && !clr |=> $stable(cnt));

    // R6: a current-value write zeroes the counter
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);

endmodule

// File: rtl/tick_flag.sv
module tick_flag (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic clr,
    input  logic rd_ctrl,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (clr)          flag <= 1'b0;
            else if (wrap)    flag <= 1'b1;
            else if (rd_ctrl) flag <= 1'b0;
            irq <= wrap && irq_en;
        end
    end

    // R4 / R5: a wrap sets the flag even when a read clears it in the same cycle
    a_r5_wrap_wins: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag);

    // R5: a read with no wrap leaves the flag clear
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd_ctrl && !wrap |=> !flag);

    // R8: irq follows a wrap only when enabled
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        wrap && irq_en |=> irq);

    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        !(wrap && irq_en) |=> !irq);

    // R6: a clear leaves the flag low
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_tick,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);

    ctrl_t         ctrl;
    bus_ops_t      ops;
    logic [CW-1:0] reload;
    logic [CW-1:0] cnt;
    logic          flag;
    logic          wrap;
    logic          cnt_en;

    assign cnt_en = ctrl.run && (ctrl.core_src || ref_tick);

    tick_regs #(.CW(CW), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .flag      (flag),
        .cnt       (cnt),
        .ctrl      (ctrl),
        .reload    (reload),
        .ops       (ops),
        .bus_rdata (bus_rdata)
    );

    tick_counter #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .clr    (ops.wr_current),
        .reload (reload),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    tick_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .clr     (ops.wr_current),
        .rd_ctrl (ops.rd_ctrl),
        .irq_en  (ctrl.irq_en),
        .flag    (flag),
        .irq     (irq)
    );

    // R9: with the reference source selected and no tick, nothing counts
    a_r9_ref_gate: assert property (@(posedge clk) disable iff (rst)
        !ctrl.core_src && !ref_tick && !ops.wr_current |=> $stable(cnt));

endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tick_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // behavioural reference
    int  m_cnt, m_rld;
    bit  m_run, m_ie, m_src, m_flag, m_irq;
    int  m_rdata;
    bit  m_rd_seen;
    int  m_rd_addr;

    always @(posedge clk) begin
        bit ce, wr_cur, wrapped;
        cyc = cyc + 1;
        if (rst) begin
            m_cnt = 0; m_rld = 0; m_run = 0; m_ie = 0; m_src = 0;
            m_flag = 0; m_irq = 0; m_rdata = 0; m_rd_seen = 0;
        end else begin
            m_rd_seen = bus_rd;
            m_rd_addr = int'(bus_addr);
            if (bus_rd) begin
                case (bus_addr)
                    4'h0: m_rdata = (int'(m_flag) << 16) | (int'(m_src) << 2)
                                  | (int'(m_ie) << 1) | int'(m_run);
                    4'h4: m_rdata = m_rld;
                    4'h8: m_rdata = m_cnt;
                    default: m_rdata = 0;
                endcase
            end
            ce = m_run && (m_src || ref_tick);
            wr_cur = bus_wr && bus_addr == 4'h8;
            wrapped = 0;
            if (wr_cur) m_cnt = 0;
            else if (ce) begin
                if (m_cnt == 0) m_cnt = m_rld;
                else begin
                    if (m_cnt == 1) wrapped = 1;
                    m_cnt = m_cnt - 1;
                end
            end
            if (wr_cur) m_flag = 0;
            else if (wrapped) m_flag = 1;
            else if (bus_rd && bus_addr == 4'h0) m_flag = 0;
            m_irq = wrapped && m_ie;
            if (bus_wr && bus_addr == 4'h0) begin
                m_run = bus_wdata[0]; m_ie = bus_wdata[1]; m_src = bus_wdata[2];
            end
            if (bus_wr && bus_addr == 4'h4) m_rld = int'(bus_wdata[23:0]);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // compare every clock, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R8 irq", {31'b0, irq}, {31'b0, m_irq});
            if (m_rd_seen) begin
                case (m_rd_addr)
                    0: chk("R5 ctrl read", bus_rdata, m_rdata);
                    4: chk("R1 reload read", bus_rdata, m_rdata);
                    8: chk("R2 current read", bus_rdata, m_rdata);
                    default: chk("R10 unmapped read", bus_rdata, m_rdata);
                endcase
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int t0, n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        rd(4'h0, d); chk("R12 ctrl", d, 32'h0);
        rd(4'h4, d); chk("R12 reload", d, 32'h0);
        rd(4'h8, d); chk("R12 current", d, 32'h0);
        chk("R12 irq", {31'b0, irq}, 32'h0);

        // R1: upper byte ignored
        wr(4'h4, 32'hAB12_3456);
        rd(4'h4, d); chk("R1 reload mask", d, 32'h0012_3456);
        // R11: data stays until next read
        @(negedge clk); chk("R11 hold", bus_rdata, 32'h0012_3456);

        // R10: unmapped offset
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, d); chk("R10 unmapped", d, 32'h0);
        rd(4'h4, d); chk("R10 no side effect", d, 32'h0012_3456);

        // R13 / R3: reload 4, core clock, irq on
        wr(4'h4, 32'h4);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h7);
        n = 0;
        do begin @(negedge clk); n++; end while (!irq && n < 50);
        chk("R13 first wrap delay", n, 5);
        t0 = cyc;
        do @(negedge clk); while (!irq);
        chk("R3 period", cyc - t0, 5);
        rd(4'h0, d); chk("R7 ctrl bits", d & 32'h7, 32'h7);

        // R5: read control every cycle across several wraps
        for (int i = 0; i < 20; i++) rd(4'h0, d);
        for (int i = 0; i < 12; i++) rd(4'h8, d);

        // R7: freeze
        wr(4'h0, 32'h6);
        rd(4'h8, d);
        repeat (4) @(negedge clk);
        begin
            logic [31:0] d2;
            rd(4'h8, d2); chk("R7 frozen", d2, d);
        end

        // R9: reference tick source
        wr(4'h4, 32'h3);
        wr(4'h0, 32'h3);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); ref_tick = (i % 3 == 0);
        end
        ref_tick = 1'b0;
        rd(4'h8, d);
        repeat (3) @(negedge clk);
        begin
            logic [31:0] d2;
            rd(4'h8, d2); chk("R9 no tick holds", d2, d);
        end

        // R6: current write restarts, ignores data, clears flag
        wr(4'h0, 32'h5);
        repeat (9) @(negedge clk);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h0, d); chk("R6 flag cleared", d & 32'h0001_0000, 32'h0);
        for (int i = 0; i < 10; i++) rd(4'h8, d);

        // R8: interrupt disabled gives no pulses (model compares irq each cycle)
        wr(4'h0, 32'h5);
        repeat (20) @(negedge clk);
        rd(4'h0, d); chk("R4 flag set", d & 32'h0001_0000, 32'h0001_0000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule